// File: doc/BRIEF.md
# Raster Sync Timing Generator with Horizontal Position Capture

This block produces the beam position and the sync signals for a raster video controller. A divider turns the master clock into a pixel-rate enable. A horizontal counter and a vertical counter advance on that enable. The horizontal counter runs over a fixed number of pixels per line. The vertical counter runs over a line count picked by a region input: a shorter frame for NTSC-compatible timing and a longer one for PAL-compatible timing. Three active-low pins leave the block: horizontal sync, vertical sync and composite sync.

Two mode bits let the sync pins carry other signals. One bit replaces the vertical sync pulse with the pixel clock. The other holds the horizontal sync pin at a constant high. The composite output is built from the raw sync pulses in every case.

An active-low capture input, driven from outside and asynchronous to the block, freezes the horizontal position so a host can read it. While the input is high, the read port tracks the running counter. After a falling edge, the read port holds the captured value for as long as the input stays low.

Top module: `vid_timing`

## Requirements
- R1: An active-low asynchronous reset clears the horizontal counter, the vertical counter, the pixel divider and the readback register. While the block is in reset, `hsync_no`, `vsync_no` and `csync_no` read 1.
- R2: `pix_en_o` pulses for one cycle in every `PIX_DIV` master clocks. The horizontal counter changes only on those cycles.
- R3: The horizontal counter runs from 0 to `H_TOTAL-1` and then wraps to 0. On that wrap the vertical counter advances by one.
- R4: With `ntsc_i`=1, the vertical counter runs from 0 to `V_NTSC-1`. With `ntsc_i`=0, it runs from 0 to `V_PAL-1`. It then wraps to 0, so that a frame lasts `H_TOTAL*V_total*PIX_DIV` clocks.
- R5: With `hs_hold_hi_i`=0, `hsync_no` is 0 exactly when the horizontal count lies in [`HS_START`, `HS_START+HS_LEN`).
- R6: With `vs_pclk_sel_i`=0, `vsync_no` is 0 exactly when the vertical count lies in [`VS_START`, `VS_START+VS_LEN`).
- R7: `csync_no` is 0 exactly when either raw sync window (R5 or R6) is active. This holds whatever the values of the two mode bits.
- R8: With `vs_pclk_sel_i`=1, `vsync_no` carries the pixel clock. It is 1 for the first `PIX_DIV/2` clocks of each pixel period, counted from the cycle on which the horizontal count changes, and 0 for the rest of the period.
- R9: With `hs_hold_hi_i`=1, `hsync_no` stays at 1.
- R10: After `hlatch_ni` falls, `hcnt_rd_o` holds the horizontal count that was present just after the second rising clock edge following the fall. It keeps that value for as long as `hlatch_ni` stays low.
- R11: While `hlatch_ni` has been high for at least four clocks, `hcnt_rd_o` equals the horizontal count of the previous clock.
- R12: `hlatch_ni` passes through a two-flop synchroniser before its falling edge is detected. The capture therefore never uses the count from the first edge after the fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ntsc_i | input | 1 | Region select: 1 = NTSC line count, 0 = PAL line count |
| vs_pclk_sel_i | input | 1 | Mode bit: 1 = vertical sync pin carries the pixel clock |
| hs_hold_hi_i | input | 1 | Mode bit: 1 = horizontal sync pin held high |
| hlatch_ni | input | 1 | Horizontal position capture, active low, asynchronous |
| pix_en_o | output | 1 | Pixel-rate enable pulse |
| hcnt_o | output | HW | Horizontal counter |
| vcnt_o | output | VW | Vertical counter |
| hcnt_rd_o | output | HW | Horizontal readback for the host |
| hsync_no | output | 1 | Horizontal sync pin, active low |
| vsync_no | output | 1 | Vertical sync pin or pixel clock, active low sync |
| csync_no | output | 1 | Composite sync, active low |

## Verification
A divider phase that slips shows up within one pixel period. It appears as an uneven spacing of `pix_en_o` and as a skewed pixel clock on `vsync_no`. A wrong horizontal wrap or sync window shows on `hsync_no` and `csync_no` within one line. A wrong vertical limit or region decode shows only at the end of a frame, as a wrong largest `vcnt_o` or a frame of the wrong length. A capture path with the wrong depth or a missing hold shows on `hcnt_rd_o` a few clocks after `hlatch_ni` changes, as a value that is off by one pixel or that keeps moving.

// File: rtl/vid_timing_pkg.sv
package vid_timing_pkg;
  typedef enum logic {
    REGION_PAL  = 1'b0,
    REGION_NTSC = 1'b1
  } region_e;

  function automatic bit in_window(input int unsigned pos, input int unsigned start,
                                   input int unsigned len);
    return (pos >= start) && (pos < start + len);
  endfunction
endpackage

// File: rtl/vt_pixdiv.sv
module vt_pixdiv #(
  parameter int unsigned PIX_DIV = 8,
  localparam int unsigned DW = (PIX_DIV > 1) ? $clog2(PIX_DIV) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic pix_en_o,
  output logic pclk_o
);
  logic [DW-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else if (pix_en_o) div_q <= '0;
    else div_q <= div_q + 1'b1;
  end

  assign pix_en_o = (div_q == DW'(PIX_DIV - 1));
  // high during first half of the pixel period
  assign pclk_o   = (div_q < DW'(PIX_DIV / 2));
endmodule

// File: rtl/vt_counters.sv
module vt_counters #(
  parameter int unsigned H_TOTAL = 342,
  parameter int unsigned V_NTSC  = 262,
  parameter int unsigned V_PAL   = 313,
  parameter int unsigned HW      = 9,
  parameter int unsigned VW      = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pix_en_i,
  input  logic          ntsc_i,
  output logic [HW-1:0] hcnt_o,
  output logic [VW-1:0] vcnt_o
);
  import vid_timing_pkg::*;

  logic [VW-1:0] v_last;
  logic          h_wrap;

  assign v_last = (region_e'(ntsc_i) == REGION_NTSC) ? VW'(V_NTSC - 1) : VW'(V_PAL - 1);
  assign h_wrap = (hcnt_o >= HW'(H_TOTAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_o <= '0;
      vcnt_o <= '0;
    end else if (pix_en_i) begin
      if (h_wrap) begin
        hcnt_o <= '0;
        // >= so a region switch late in a frame still wraps
        vcnt_o <= (vcnt_o >= v_last) ? '0 : vcnt_o + 1'b1;
      end else begin
        hcnt_o <= hcnt_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vt_sync_gen.sv
module vt_sync_gen #(
  parameter int unsigned HS_START = 300,
  parameter int unsigned HS_LEN   = 26,
  parameter int unsigned VS_START = 230,
  parameter int unsigned VS_LEN   = 3,
  parameter int unsigned HW       = 9,
  parameter int unsigned VW       = 9
) (
  input  logic          rst_ni,
  input  logic [HW-1:0] hcnt_i,
  input  logic [VW-1:0] vcnt_i,
  input  logic          pclk_i,
  input  logic          vs_pclk_sel_i,
  input  logic          hs_hold_hi_i,
  output logic          hsync_no,
  output logic          vsync_no,
  output logic          csync_no
);
  import vid_timing_pkg::*;

  logic hs_act, vs_act;

  always_comb begin
    hs_act = rst_ni && in_window(32'(hcnt_i), HS_START, HS_LEN);
    vs_act = rst_ni && in_window(32'(vcnt_i), VS_START, VS_LEN);
    hsync_no = hs_hold_hi_i ? 1'b1 : !hs_act;
    if (!rst_ni) vsync_no = 1'b1;
    else if (vs_pclk_sel_i) vsync_no = pclk_i;
    else vsync_no = !vs_act;
    csync_no = !(hs_act || vs_act);
  end
endmodule

// File: rtl/vt_hlatch.sv
module vt_hlatch #(
  parameter int unsigned HW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hlatch_ni,
  input  logic [HW-1:0] hcnt_i,
  output logic [HW-1:0] hcnt_rd_o
);
  logic s1_q, s2_q, s3_q, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      s3_q <= 1'b1;
    end else begin
      s1_q <= hlatch_ni;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign fall = s3_q && !s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hcnt_rd_o <= '0;
    else if (s2_q || fall) hcnt_rd_o <= hcnt_i;
  end
endmodule

// File: rtl/vid_timing.sv
module vid_timing #(
  parameter int unsigned PIX_DIV  = 8,
  parameter int unsigned H_TOTAL  = 342,
  parameter int unsigned V_NTSC   = 262,
  parameter int unsigned V_PAL    = 313,
  parameter int unsigned HS_START = 300,
  parameter int unsigned HS_LEN   = 26,
  parameter int unsigned VS_START = 230,
  parameter int unsigned VS_LEN   = 3,
  localparam int unsigned V_MAX   = (V_PAL > V_NTSC) ? V_PAL : V_NTSC,
  localparam int unsigned HW      = $clog2(H_TOTAL),
  localparam int unsigned VW      = $clog2(V_MAX)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ntsc_i,
  input  logic          vs_pclk_sel_i,
  input  logic          hs_hold_hi_i,
  input  logic          hlatch_ni,
  output logic          pix_en_o,
  output logic [HW-1:0] hcnt_o,
  output logic [VW-1:0] vcnt_o,
  output logic [HW-1:0] hcnt_rd_o,
  output logic          hsync_no,
  output logic          vsync_no,
  output logic          csync_no
);
  logic pclk;

  vt_pixdiv #(.PIX_DIV(PIX_DIV)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .pix_en_o(pix_en_o), .pclk_o(pclk)
  );

  vt_counters #(.H_TOTAL(H_TOTAL), .V_NTSC(V_NTSC), .V_PAL(V_PAL), .HW(HW), .VW(VW)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .pix_en_i(pix_en_o), .ntsc_i(ntsc_i),
    .hcnt_o(hcnt_o), .vcnt_o(vcnt_o)
  );

  vt_sync_gen #(.HS_START(HS_START), .HS_LEN(HS_LEN), .VS_START(VS_START), .VS_LEN(VS_LEN),
                .HW(HW), .VW(VW)) u_sync (
    .rst_ni(rst_ni), .hcnt_i(hcnt_o), .vcnt_i(vcnt_o), .pclk_i(pclk),
    .vs_pclk_sel_i(vs_pclk_sel_i), .hs_hold_hi_i(hs_hold_hi_i),
    .hsync_no(hsync_no), .vsync_no(vsync_no), .csync_no(csync_no)
  );

  vt_hlatch #(.HW(HW)) u_latch (
    .clk_i(clk_i), .rst_ni(rst_ni), .hlatch_ni(hlatch_ni), .hcnt_i(hcnt_o),
    .hcnt_rd_o(hcnt_rd_o)
  );
endmodule

// File: rtl/vid_timing_chk.sv
module vid_timing_chk #(
  parameter int unsigned H_TOTAL = 342,
  parameter int unsigned V_MAX   = 313,
  parameter int unsigned HW      = 9,
  parameter int unsigned VW      = 9
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          vs_pclk_sel_i,
  input logic          hs_hold_hi_i,
  input logic          hlatch_ni,
  input logic          pix_en_o,
  input logic [HW-1:0] hcnt_o,
  input logic [VW-1:0] vcnt_o,
  input logic [HW-1:0] hcnt_rd_o,
  input logic          hsync_no,
  input logic          vsync_no,
  input logic          csync_no
);
  AST_RESET_PINS: assert property (@(posedge clk_i) !rst_ni |-> (hsync_no && vsync_no && csync_no)); // R1
  AST_PIXEN_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_en_o |=> !pix_en_o); // R2
  AST_H_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_en_o |=> $stable(hcnt_o)); // R2
  AST_H_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_en_o && hcnt_o < HW'(H_TOTAL - 1)) |=> hcnt_o == $past(hcnt_o) + 1'b1); // R3
  AST_H_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_en_o && hcnt_o == HW'(H_TOTAL - 1)) |=> (hcnt_o == '0 && vcnt_o != $past(vcnt_o))); // R3
  AST_V_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vcnt_o < VW'(V_MAX)); // R4
  AST_HS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_hold_hi_i |-> hsync_no); // R9
  AST_CSYNC_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hs_hold_hi_i && !vs_pclk_sel_i && !csync_no) |-> (!hsync_no || !vsync_no)); // R7
  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hlatch_ni && !$past(hlatch_ni) && !$past(hlatch_ni, 2) && !$past(hlatch_ni, 3)
     && !$past(hlatch_ni, 4) && $past(rst_ni, 4)) |-> $stable(hcnt_rd_o)); // R10
  AST_LATCH_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hlatch_ni && $past(hlatch_ni) && $past(hlatch_ni, 2) && $past(hlatch_ni, 3)
     && $past(rst_ni, 4)) |-> hcnt_rd_o == $past(hcnt_o)); // R11
endmodule

bind vid_timing vid_timing_chk #(.H_TOTAL(H_TOTAL), .V_MAX(V_MAX), .HW(HW), .VW(VW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .vs_pclk_sel_i(vs_pclk_sel_i), .hs_hold_hi_i(hs_hold_hi_i),
  .hlatch_ni(hlatch_ni), .pix_en_o(pix_en_o), .hcnt_o(hcnt_o), .vcnt_o(vcnt_o),
  .hcnt_rd_o(hcnt_rd_o), .hsync_no(hsync_no), .vsync_no(vsync_no), .csync_no(csync_no)
);

// File: tb/vid_timing_tb.sv
module vid_timing_tb;
  localparam int DIV = 4, HT = 24, VN = 10, VP = 13, HSS = 18, HSL = 3, VSS = 6, VSL = 2;
  localparam int HW = $clog2(HT), VW = $clog2(VP);

  logic clk = 0, rst_ni = 0, ntsc_i = 1, vs_sel = 0, hs_hold = 0, hl_n = 1;
  logic pix_en, hs_n, vs_n, cs_n;
  logic [HW-1:0] hcnt, hrd;
  logic [VW-1:0] vcnt;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vid_timing #(.PIX_DIV(DIV), .H_TOTAL(HT), .V_NTSC(VN), .V_PAL(VP), .HS_START(HSS),
               .HS_LEN(HSL), .VS_START(VSS), .VS_LEN(VSL)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ntsc_i(ntsc_i), .vs_pclk_sel_i(vs_sel),
    .hs_hold_hi_i(hs_hold), .hlatch_ni(hl_n), .pix_en_o(pix_en), .hcnt_o(hcnt),
    .vcnt_o(vcnt), .hcnt_rd_o(hrd), .hsync_no(hs_n), .vsync_no(vs_n), .csync_no(cs_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit hs_win(int h); return h >= HSS && h < HSS + HSL; endfunction
  function automatic bit vs_win(int v); return v >= VSS && v < VSS + VSL; endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // wait until hcnt just changed (sampled at negedge)
  task automatic align_pixel();
    logic [HW-1:0] p;
    @(negedge clk); p = hcnt;
    forever begin
      @(negedge clk);
      if (hcnt != p) break;
      p = hcnt;
    end
  endtask

  task automatic t_reset();
    rst_ni = 0;
    repeat (3) @(negedge clk);
    check(hcnt == 0 && vcnt == 0 && hrd == 0, "R1 counters", int'(hcnt) + int'(vcnt) + int'(hrd), 0);
    check(hs_n && vs_n && cs_n, "R1 sync pins", {hs_n, vs_n, cs_n}, 7);
    rst_ni = 1;
  endtask

  task automatic t_pixel_rate();
    int n = 1;
    logic [HW-1:0] p;
    align_pixel(); p = hcnt;
    forever begin
      @(negedge clk);
      if (hcnt != p) break;
      n++;
    end
    check(n == DIV, "R2 pixel period", n, DIV);
  endtask

  task automatic t_line_wrap();
    logic [VW-1:0] v0;
    int vt;
    vt = ntsc_i ? VN : VP;
    do @(negedge clk); while (hcnt != HW'(HT - 1));
    v0 = vcnt;
    do @(negedge clk); while (hcnt == HW'(HT - 1));
    check(hcnt == 0, "R3 h wrap", hcnt, 0);
    check(int'(vcnt) == (int'(v0) + 1) % vt, "R3 v step", vcnt, (int'(v0) + 1) % vt);
  endtask

  // one full frame: limits (R4) and sync windows (R5,R6,R7)
  task automatic t_frame(input bit ntsc);
    int vt, vmax = 0, e_hs = 0, e_vs = 0, e_cs = 0;
    @(negedge clk); ntsc_i = ntsc;
    vt = ntsc ? VN : VP;
    do @(negedge clk); while (!(hcnt == 0 && vcnt == 0));
    do @(negedge clk); while (!(hcnt == 0 && vcnt == 0));
    for (int i = 0; i < HT * vt * DIV; i++) begin
      if (int'(vcnt) > vmax) vmax = int'(vcnt);
      if (hs_n != !hs_win(hcnt)) e_hs++;
      if (vs_n != !vs_win(vcnt)) e_vs++;
      if (cs_n != !(hs_win(hcnt) || vs_win(vcnt))) e_cs++;
      @(negedge clk);
    end
    check(vmax == vt - 1, ntsc ? "R4 ntsc last line" : "R4 pal last line", vmax, vt - 1);
    check(hcnt == 0 && vcnt == 0, "R4 frame length", int'(hcnt) + int'(vcnt), 0);
    check(e_hs == 0, "R5 hsync window", e_hs, 0);
    check(e_vs == 0, "R6 vsync window", e_vs, 0);
    check(e_cs == 0, "R7 composite", e_cs, 0);
  endtask

  task automatic t_pclk_mode();
    int err = 0;
    vs_sel = 1;
    align_pixel();
    for (int i = 0; i < DIV * 30; i++) begin
      if (vs_n != ((i % DIV) < DIV / 2)) err++;
      @(negedge clk);
    end
    check(err == 0, "R8 pixel clock on vsync pin", err, 0);
    vs_sel = 0;
  endtask

  task automatic t_hs_hold();
    int e_hs = 0, e_cs = 0;
    hs_hold = 1;
    vs_sel = 1;
    @(negedge clk);
    for (int i = 0; i < HT * DIV * 3; i++) begin
      if (!hs_n) e_hs++;
      if (cs_n != !(hs_win(hcnt) || vs_win(vcnt))) e_cs++;
      @(negedge clk);
    end
    check(e_hs == 0, "R9 hsync held high", e_hs, 0);
    check(e_cs == 0, "R7 composite with both mode bits set", e_cs, 0);
    hs_hold = 0;
    vs_sel = 0;
  endtask

  task automatic t_capture();
    logic [HW-1:0] exp, first;
    int moved = 0, changed = 0;
    @(negedge clk); hl_n = 0;
    @(posedge clk); first = hcnt;
    @(posedge clk);
    @(negedge clk); exp = hcnt;
    repeat (2) @(negedge clk);
    for (int i = 0; i < DIV * 10; i++) begin
      if (hcnt != exp) moved = 1;
      if (hrd != exp) changed++;
      @(negedge clk);
    end
    check(hrd == exp, "R10 captured value", hrd, exp);
    check(changed == 0 && moved == 1, "R10 frozen while low", changed, 0);
    check(!(exp != first && hrd == first), "R12 two-flop delay", hrd, exp);
    hl_n = 1;
  endtask

  task automatic t_track();
    logic [HW-1:0] p;
    int err = 0;
    repeat (5) @(negedge clk);
    p = hcnt;
    for (int i = 0; i < DIV * 12; i++) begin
      @(negedge clk);
      if (hrd != p) err++;
      p = hcnt;
    end
    check(err == 0, "R11 readback follows counter", err, 0);
  endtask

  initial begin
    #(20 * 100000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_pixel_rate();
    t_line_wrap();
    t_frame(1);
    t_frame(0);
    t_line_wrap();
    t_pclk_mode();
    t_hs_hold();
    t_capture();
    t_track();
    // capture once more at a different phase
    repeat (7) @(negedge clk);
    t_capture();
    t_track();
    t_reset();
    finish_run();
  end
endmodule